// File: doc/BRIEF.md
# SPI Master Burst and Chip-Select Sequencer

This block runs the byte bursts of an SPI master. Static settings come from control fields: enable, clock polarity, chip-select polarity, manual chip-select override with its level, discard-receive, the select index and the burst length. A one-cycle start request launches a burst when the block is enabled. The burst takes bytes from a show-ahead transmit FIFO and shifts them out on MOSI, most significant bit first. It assembles the MISO bits into bytes and pushes them to a receive FIFO. After the programmed number of bytes it signals completion. SCLK edges are paced by a clock-enable strobe from an external divider. Each strobe produces one half period.

The busy flag stands for the self-clearing exchange bit. It rises when a start is accepted and falls when the burst ends. The completion pulse comes in the last busy cycle. When the transmit FIFO runs dry mid-burst, the block holds SCLK and waits. Chip-select lines idle at a level set by the polarity bit. In automatic mode the selected line goes active for the whole burst. In manual mode it follows a level bit.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: A start request while en_i is low is ignored: xfer_busy_o stays 0, no completion pulse and no FIFO pop follow.
- R2: xfer_busy_o rises the cycle after an accepted start and stays high until the burst ends. xfer_done_o is a one-cycle pulse in the last busy cycle, and xfer_busy_o is 0 in the cycle after it.
- R3: A burst of length N pops exactly N transmit bytes. Each is sent on MOSI MSB first, and each bit is valid before the SCLK edge that samples it.
- R4: MISO is sampled on the leading SCLK edge of each bit (leading = edge away from the idle level). Bits are assembled MSB first, and each completed byte is pushed once with rx_push_o.
- R5: With rx_discard_i set, rx_push_o stays 0 for the whole burst.
- R6: While no burst runs, sclk_o equals cpol_i. During a burst, SCLK changes only in the cycle after a clk_en_i strobe, giving 16 edges per byte.
- R7: While tx_empty_i is high, tx_pop_o stays 0. A burst waiting for data holds SCLK still and resumes when data arrives.
- R8: A chip-select line idles at 1 when cs_act_low_i is 1 and at 0 when it is 0. In automatic mode, line cs_sel_i takes the opposite level while busy. Unselected lines always sit at the idle level.
- R9: With cs_manual_i set, line cs_sel_i equals cs_level_i whether or not a burst runs.
- R10: A start with length 0 gives xfer_done_o on the next cycle, with no SCLK edge and no pop.
- R11: Dropping en_i during a burst aborts it: xfer_busy_o falls on the next cycle, SCLK returns to idle, and no completion pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| cpol_i | input | 1 | SCLK idle level |
| cs_manual_i | input | 1 | Chip select follows cs_level_i |
| cs_level_i | input | 1 | Manual chip-select level |
| cs_act_low_i | input | 1 | Idle chip-select level (1 = idle high) |
| rx_discard_i | input | 1 | Drop received bytes |
| cs_sel_i | input | SEL_W | Index of the chip-select line in use |
| xfer_len_i | input | CNT_W | Burst length in bytes |
| xfer_go_i | input | 1 | Start request pulse |
| xfer_busy_o | output | 1 | Exchange in progress (self-clearing) |
| xfer_done_o | output | 1 | Transfer complete pulse |
| clk_en_i | input | 1 | Half-period strobe from the divider |
| tx_data_i | input | DATA_W | Head of the transmit FIFO |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_pop_o | output | 1 | Transmit FIFO pop |
| rx_data_o | output | DATA_W | Received byte |
| rx_push_o | output | 1 | Receive FIFO push |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NUM_CS | Chip-select lines |

## Verification
The bench builds the block with DATA_W=8, NUM_CS=4 and CNT_W=4. The narrow count lets a burst of the maximum length of 15 bytes run in a short time, so the counter's top value is exercised alongside the zero-length burst. Four select lines let every select index, and the lines left unselected, be checked in both polarities. Clock-enable strobes alternate between every cycle and a sparse random pattern, so both back-to-back SCLK edges and long gaps occur.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FETCH,
    SEQ_SHIFT,
    SEQ_FIN
  } seq_state_e;
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              cpol_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, rx_q;
  logic [BIT_W-1:0]  bit_q;
  logic              lvl_q;  // 0: idle phase, 1: after leading edge
  logic              last;

  assign last = (bit_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
      lvl_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= data_i;
      bit_q <= '0;
      lvl_q <= 1'b0;
    end else if (!run_i) begin
      lvl_q <= 1'b0;
    end else if (tick_i) begin
      if (!lvl_q) begin
        lvl_q <= 1'b1;
        rx_q  <= {rx_q[DATA_W-2:0], miso_i};
      end else begin
        lvl_q <= 1'b0;
        if (!last) begin
          sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o      = cpol_i ^ lvl_q;
  assign mosi_o      = sh_q[DATA_W-1];
  assign byte_done_o = run_i && tick_i && lvl_q && last;
  assign rx_byte_o   = rx_q;
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              discard_i,
  input  logic              tx_empty_i,
  input  logic              byte_done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              busy_o,
  output logic              run_o,
  output logic              load_o,
  output logic              done_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  remain_q;
  logic              push_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (en_i && go_i) state_d = (len_i == '0) ? SEQ_FIN : SEQ_FETCH;
      SEQ_FETCH: if (!en_i) state_d = SEQ_IDLE;
                 else if (!tx_empty_i) state_d = SEQ_SHIFT;
      SEQ_SHIFT: if (!en_i) state_d = SEQ_IDLE;
                 else if (byte_done_i) state_d = (remain_q == ONE) ? SEQ_FIN : SEQ_FETCH;
      SEQ_FIN:   state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      remain_q <= '0;
      push_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_IDLE && en_i && go_i) remain_q <= len_i;
      else if (run_o && byte_done_i) remain_q <= remain_q - ONE;
      push_q <= run_o && byte_done_i && !discard_i;
      if (run_o && byte_done_i) data_q <= rx_byte_i;
    end
  end

  assign busy_o    = (state_q != SEQ_IDLE);
  assign run_o     = (state_q == SEQ_SHIFT) && en_i;
  assign load_o    = (state_q == SEQ_FETCH) && en_i && !tx_empty_i;
  assign done_o    = (state_q == SEQ_FIN);
  assign rx_push_o = push_q;
  assign rx_data_o = data_q;
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic              busy_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              manual_i,
  input  logic              level_i,
  input  logic              act_low_i,
  output logic [NUM_CS-1:0] cs_o
);
  logic auto_lvl, sel_lvl;

  assign auto_lvl = busy_i ? ~act_low_i : act_low_i;
  assign sel_lvl  = manual_i ? level_i : auto_lvl;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_o[i] = (sel_i == SEL_W'(i)) ? sel_lvl : act_low_i;
  end
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cs_manual_i,
  input  logic              cs_level_i,
  input  logic              cs_act_low_i,
  input  logic              rx_discard_i,
  input  logic [SEL_W-1:0]  cs_sel_i,
  input  logic [CNT_W-1:0]  xfer_len_i,
  input  logic              xfer_go_i,
  output logic              xfer_busy_o,
  output logic              xfer_done_o,
  input  logic              clk_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_empty_i,
  output logic              tx_pop_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_push_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o
);
  logic              run, load, byte_done, busy;
  logic [DATA_W-1:0] rx_byte;

  spi_burst_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .go_i        (xfer_go_i),
    .len_i       (xfer_len_i),
    .discard_i   (rx_discard_i),
    .tx_empty_i  (tx_empty_i),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .busy_o      (busy),
    .run_o       (run),
    .load_o      (load),
    .done_o      (xfer_done_o),
    .rx_push_o   (rx_push_o),
    .rx_data_o   (rx_data_o)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .data_i      (tx_data_i),
    .run_i       (run),
    .tick_i      (clk_en_i),
    .cpol_i      (cpol_i),
    .miso_i      (miso_i),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) i_cs (
    .busy_i    (busy),
    .sel_i     (cs_sel_i),
    .manual_i  (cs_manual_i),
    .level_i   (cs_level_i),
    .act_low_i (cs_act_low_i),
    .cs_o      (cs_o)
  );

  assign xfer_busy_o = busy;
  assign tx_pop_o    = load;
endmodule

// File: rtl/spi_xfer_ctrl_chk.sv
module spi_xfer_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              cpol_i,
  input logic              cs_manual_i,
  input logic              cs_level_i,
  input logic              cs_act_low_i,
  input logic              rx_discard_i,
  input logic [SEL_W-1:0]  cs_sel_i,
  input logic [CNT_W-1:0]  xfer_len_i,
  input logic              xfer_go_i,
  input logic              xfer_busy_o,
  input logic              xfer_done_o,
  input logic              clk_en_i,
  input logic [DATA_W-1:0] tx_data_i,
  input logic              tx_empty_i,
  input logic              tx_pop_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_push_o,
  input logic              sclk_o,
  input logic              mosi_o,
  input logic              miso_i,
  input logic [NUM_CS-1:0] cs_o
);
  a_r1_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_busy_o && !en_i) |=> !xfer_busy_o);

  a_r2_done_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> xfer_busy_o);

  a_r2_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |=> !xfer_busy_o);

  a_r3_pop_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |=> !tx_pop_o);

  a_r5_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rx_discard_i) |-> !rx_push_o);

  a_r6_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_busy_o |-> (sclk_o == cpol_i));

  a_r6_edge_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_busy_o && $past(xfer_busy_o) && $stable(cpol_i) && (sclk_o != $past(sclk_o)))
      |-> $past(clk_en_i));

  a_r7_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_i |-> !tx_pop_o);

  a_r8_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_busy_o && !cs_manual_i) |-> (cs_o == {NUM_CS{cs_act_low_i}}));

  a_r8_one_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ {NUM_CS{cs_act_low_i}}) <= 1);

  a_r9_manual_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_manual_i |-> (cs_o[cs_sel_i] == cs_level_i));

  a_r10_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_go_i && en_i && !xfer_busy_o && (xfer_len_i == '0)) |=> xfer_done_o);

  a_r11_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_busy_o && !en_i && !xfer_done_o) |=> (!xfer_busy_o && !xfer_done_o));
endmodule

bind spi_xfer_ctrl spi_xfer_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_CS(NUM_CS)) i_chk (.*);

// File: tb/test_spi_xfer_ctrl.sv
module test_spi_xfer_ctrl;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int NC = 4;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic en = 1'b1, cpol = 1'b0, csm = 1'b0, csl = 1'b0, cal = 1'b1, disc = 1'b0;
  logic [SW-1:0] sel = '0;
  logic [CW-1:0] len = '0;
  logic go = 1'b0;
  logic clk_en = 1'b0;
  logic [DW-1:0] tx_data, rx_data;
  logic tx_empty, tx_pop, rx_push, sclk, mosi, miso, busy, done;
  logic [NC-1:0] cs;

  logic [7:0] tx_mem [256];
  logic [7:0] slv_mem [256];
  logic [7:0] mosi_log [256];
  logic [7:0] rx_log [256];
  int rd = 0, tx_lim = 0, mcnt = 0, rx_cnt = 0, done_cnt = 0, edges = 0, bad_done = 0, sbit = 0;
  int tb_i, mb_i, rb_i, db_i, eb_i;
  logic [7:0] mbyte = '0;
  logic sclk_prev = 1'b0;
  bit fast = 1'b1;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  spi_xfer_ctrl #(.DATA_W(DW), .CNT_W(CW), .NUM_CS(NC)) i_spi_xfer_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cs_manual_i(csm),
    .cs_level_i(csl), .cs_act_low_i(cal), .rx_discard_i(disc), .cs_sel_i(sel),
    .xfer_len_i(len), .xfer_go_i(go), .xfer_busy_o(busy), .xfer_done_o(done),
    .clk_en_i(clk_en), .tx_data_i(tx_data), .tx_empty_i(tx_empty), .tx_pop_o(tx_pop),
    .rx_data_o(rx_data), .rx_push_o(rx_push), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_o(cs)
  );

  assign tx_empty = (rd >= tx_lim);
  assign tx_data  = tx_mem[rd % 256];
  assign miso     = slv_mem[mcnt % 256][7 - sbit];

  always @(posedge clk) begin
    if (tx_pop) rd <= rd + 1;
    clk_en <= fast ? 1'b1 : ($urandom % 3 == 0);
  end

  // slave model and output logging
  always @(negedge clk) begin
    if (busy && sclk !== sclk_prev) begin
      edges++;
      if (sclk != cpol) mbyte = {mbyte[6:0], mosi};
      else begin
        sbit++;
        if (sbit == 8) begin
          mosi_log[mcnt % 256] = mbyte;
          mcnt++;
          sbit = 0;
        end
      end
    end
    if (!busy) sbit = 0;
    sclk_prev = sclk;
    if (rx_push) begin
      rx_log[rx_cnt % 256] = rx_data;
      rx_cnt++;
    end
    if (done) begin
      done_cnt++;
      if (!busy) bad_done++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_cs(bit b);
    logic [NC-1:0] v;
    for (int i = 0; i < NC; i++)
      v[i] = (int'(sel) == i) ? (csm ? csl : (b ? ~cal : cal)) : cal;
    return v;
  endfunction

  task automatic prep(int n, bit cp, bit ds, int s, bit al, bit stall);
    @(negedge clk);
    cpol = cp; disc = ds; sel = SW'(s); cal = al;
    tb_i = rd; mb_i = mcnt; rb_i = rx_cnt; db_i = done_cnt; eb_i = edges;
    for (int i = 0; i < n; i++) begin
      tx_mem[(tb_i + i) % 256]  = 8'($urandom);
      slv_mem[(mb_i + i) % 256] = 8'($urandom);
    end
    tx_lim = stall ? tb_i + 1 : tb_i + n;
  endtask

  task automatic start(int n);
    @(negedge clk);
    len = CW'(n);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
  endtask

  task automatic mid_cs();
    while (rd == tb_i) @(posedge clk);
    @(negedge clk);
    chk(cs == exp_cs(1'b1), "R8/R9 cs during burst", cs, exp_cs(1'b1));
  endtask

  task automatic verify(int n);
    int bad_m, bad_r;
    int t = 0;
    while (done_cnt == db_i && t < 20000) begin
      @(posedge clk);
      t++;
    end
    @(negedge clk);
    chk(done_cnt - db_i == 1, "R2 one done pulse", done_cnt - db_i, 1);
    chk(busy == 1'b0, "R2 busy cleared", busy, 0);
    chk(rd - tb_i == n, "R3 pops", rd - tb_i, n);
    chk(mcnt - mb_i == n, "R3 bytes on wire", mcnt - mb_i, n);
    bad_m = 0; bad_r = 0;
    for (int i = 0; i < n; i++) begin
      if (mosi_log[(mb_i + i) % 256] != tx_mem[(tb_i + i) % 256]) bad_m++;
      if (!disc && rx_log[(rb_i + i) % 256] != slv_mem[(mb_i + i) % 256]) bad_r++;
    end
    chk(bad_m == 0, "R3 mosi bytes MSB first", bad_m, 0);
    if (disc) chk(rx_cnt == rb_i, "R5 no push when discarding", rx_cnt - rb_i, 0);
    else begin
      chk(rx_cnt - rb_i == n, "R4 push count", rx_cnt - rb_i, n);
      chk(bad_r == 0, "R4 miso bytes", bad_r, 0);
    end
    chk(edges - eb_i == 16 * n, "R6 edge count", edges - eb_i, 16 * n);
    chk(sclk == cpol, "R6 sclk idle", sclk, cpol);
    chk(cs == exp_cs(1'b0), "R8 cs idle after", cs, exp_cs(1'b0));
    chk(bad_done == 0, "R2 done inside busy", bad_done, 0);
  endtask

  task automatic run_full(int n, bit cp, bit ds, int s, bit al);
    prep(n, cp, ds, s, al, 1'b0);
    start(n);
    mid_cs();
    verify(n);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int e;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R2 reset busy", busy, 0);
    chk(done == 1'b0 && tx_pop == 1'b0 && rx_push == 1'b0, "R2 reset strobes", {done, tx_pop, rx_push}, 0);
    chk(sclk == cpol, "R6 reset sclk idle", sclk, cpol);
    chk(cs == {NC{cal}}, "R8 reset cs idle high", cs, {NC{cal}});

    // random bursts
    for (int k = 0; k < 8; k++) begin
      fast = 1'($urandom % 2);
      run_full(1 + int'($urandom % 8), 1'($urandom), 1'($urandom), int'($urandom % NC), 1'($urandom));
    end

    // maximum length, sparse ticks
    fast = 1'b0;
    run_full(15, 1'b1, 1'b0, 3, 1'b1);

    // idle-low polarity, active high while busy
    fast = 1'b1;
    run_full(2, 1'b0, 1'b0, 1, 1'b0);

    // transmit stall
    prep(3, 1'b0, 1'b0, 0, 1'b1, 1'b1);
    start(3);
    while (mcnt == mb_i) @(posedge clk);
    e = edges;
    repeat (30) @(posedge clk);
    chk(edges == e, "R7 sclk held while empty", edges - e, 0);
    chk(rd == tb_i + 1, "R7 no pop while empty", rd - tb_i, 1);
    @(negedge clk);
    chk(busy == 1'b1, "R7 still busy in stall", busy, 1);
    tx_lim = tb_i + 3;
    verify(3);

    // zero length
    prep(0, 1'b1, 1'b0, 0, 1'b1, 1'b0);
    start(0);
    verify(0);
    chk(edges == eb_i && rd == tb_i, "R10 no edges or pops", edges - eb_i, 0);

    // start while disabled
    prep(2, 1'b0, 1'b0, 0, 1'b1, 1'b0);
    en = 1'b0;
    @(negedge clk); go = 1'b1; len = CW'(2);
    @(negedge clk); go = 1'b0;
    chk(busy == 1'b0, "R1 ignored start", busy, 0);
    repeat (20) @(posedge clk);
    chk(done_cnt == db_i && rd == tb_i, "R1 no done no pop", done_cnt - db_i, 0);
    @(negedge clk); en = 1'b1;
    tx_lim = rd;

    // manual chip select
    @(negedge clk); csm = 1'b1; csl = 1'b0; sel = 2'd2; cal = 1'b1;
    @(negedge clk);
    chk(cs == 4'b1011, "R9 manual low idle", cs, 4'b1011);
    csl = 1'b1;
    @(negedge clk);
    chk(cs == 4'b1111, "R9 manual high idle", cs, 4'b1111);
    csl = 1'b0;
    run_full(2, 1'b0, 1'b1, 2, 1'b1);
    csm = 1'b0;

    // abort by disabling
    fast = 1'b0;
    prep(4, 1'b1, 1'b0, 1, 1'b1, 1'b0);
    start(4);
    while (rd == tb_i) @(posedge clk);
    repeat (6) @(posedge clk);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 abort clears busy", busy, 0);
    chk(sclk == cpol, "R11 sclk idle after abort", sclk, cpol);
    repeat (20) @(posedge clk);
    chk(done_cnt == db_i, "R11 no done on abort", done_cnt - db_i, 0);
    @(negedge clk); en = 1'b1; fast = 1'b1;

    // recovery after abort
    run_full(3, 1'b0, 1'b0, 0, 1'b1);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual finished=0 expected 1");
      summary();
      $finish;
    end
  end
endmodule